// File: doc/BRIEF.md
# Fixed-Width Signed Multiplier with Adaptive Truncation Bias

This block multiplies two N-bit two's-complement operands and delivers only the upper N bits of the 2N-bit product. It is meant for signal-processing datapaths where operands and results share one word length. The full product array is never built. The block forms a signed partial-product array with inverted sign-cross terms and a pair of fixed correction constants. It keeps only the N+1 most significant columns of that array, and in place of the dropped low-order columns it adds a bias that depends on the operands.

The bias is computed from the first dropped column, the index column at weight 2^(N-2). Its partial-product bits are counted. Half of that count, rounded up, forms a coarse estimate of the carry the dropped columns would have sent upward. A fine constant of one is added to it. The total is injected as carry-in at column N-1, the least significant kept column. After the final add the result is taken from columns 2N-1 down to N. An optional output register gives one cycle of latency and clears synchronously on reset.

Top module: `fwm_trunc_mul`

## Requirements
- R1: With D the value of all magnitude-by-magnitude pairs a[i]&b[j] (i,j ≤ N-2) with i+j ≤ N-2, each weighted 2^(i+j), and S the count of those pairs with i+j = N-2, the output equals the low N bits of floor((a·b − D + B·2^(N-1)) / 2^N), where B = ceil(S/2) + 1 and a, b are read as two's-complement.
- R2: For N = 8 the output differs from floor(a·b / 2^N) by at most one output LSB, for every operand pair.
- R3: When either operand is zero the output is zero.
- R4: When both operands hold the most negative value −2^(N-1), the output is exactly 2^(N-2).
- R5: Over all operand pairs, the summed absolute error against the exact scaled product a·b/2^N is strictly smaller than that of plain truncation, which drops every column below N without any bias.
- R6: With the registered stage selected (default), the output changes only at a rising clock edge and shows the result for the operands present at that edge. A synchronous active-high reset drives the output to zero.
- R7: Full-scale operands of mixed sign (−2^(N-1) times 2^(N-1)−1, in either order) give −(2^(N-2)−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset, clears the registered output |
| op_a | input | N | Multiplicand, two's-complement |
| op_b | input | N | Multiplier, two's-complement |
| prod | output | N | Upper N bits of the compensated product, two's-complement |

## Verification
The bench targets the sign extremes. It squares the most negative value, where a wrong sign-cross inversion or a missing correction constant flips the result to a large negative number. It multiplies the most negative value by the most positive, where a misplaced constant shifts the answer by a whole LSB. Zero operands expose a bias that leaks into the result when nothing should be added. A full operand sweep compares every output bit with an arithmetic model of the bias rule. That sweep catches an index column taken one position off and a fine constant that is missing or doubled, because either change moves many results by one LSB. A final comparison of accumulated error against plain truncation shows whether the compensation actually reduces error.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    // number of columns kept beyond the N output columns
    localparam int FWM_KEEP_EXTRA = 1;

    // constant added on top of the coarse carry estimate, in units of column N-1
    localparam int FWM_FINE_K = 1;

    typedef enum logic {
        FWM_COMB = 1'b0,
        FWM_REG  = 1'b1
    } fwm_stage_e;

    // a sign bit paired with a magnitude bit of the other operand
    function automatic logic fwm_sign_mix(int i, int j, int n);
        return (i == n - 1) != (j == n - 1);
    endfunction

    // partial product lands in a column that is built in hardware
    function automatic logic fwm_col_kept(int i, int j, int n);
        return (i + j) >= (n - FWM_KEEP_EXTRA);
    endfunction

    // partial product lands in the first dropped column
    function automatic logic fwm_in_index(int i, int j, int n);
        return (i + j) == (n - FWM_KEEP_EXTRA - 1);
    endfunction

    // width wide enough to count up to n index bits plus the bias constant
    function automatic int fwm_cnt_w(int n);
        return $clog2(n + 2) + 1;
    endfunction

endpackage

// File: rtl/fwm_pp_array.sv
module fwm_pp_array
    import fwm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]         a,
    input  logic [N-1:0]         b,
    output logic [N-1:0][N-1:0]  pp
);

    // pp[i][j] sits in column i+j; cross terms with exactly one sign bit are inverted
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (fwm_sign_mix(gi, gj, N)) begin : g_nand
                assign pp[gi][gj] = ~(a[gi] & b[gj]);
            end else begin : g_and
                assign pp[gi][gj] = a[gi] & b[gj];
            end
        end
    end

endmodule

// File: rtl/fwm_bias_gen.sv
module fwm_bias_gen
    import fwm_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = fwm_cnt_w(N),
    localparam int IDX = N - FWM_KEEP_EXTRA
) (
    input  logic [N-1:0][N-1:0] pp,
    output logic [CW-1:0]       bias
);

    logic [IDX-1:0] idx_bits;
    logic [CW-1:0]  idx_cnt;
    logic [CW-1:0]  coarse;

    // index column: pairs whose weights sum to IDX-1
    for (genvar gi = 0; gi < IDX; gi++) begin : g_idx
        assign idx_bits[gi] = pp[gi][IDX-1-gi];
    end

    always_comb begin
        idx_cnt = '0;
        for (int k = 0; k < IDX; k++) begin
            idx_cnt = idx_cnt + CW'(idx_bits[k]);
        end
    end

    // half the index weight moved up one column, rounded up
    assign coarse = (idx_cnt + CW'(1)) >> 1;
    assign bias   = coarse + CW'(FWM_FINE_K);

endmodule

// File: rtl/fwm_col_sum.sv
module fwm_col_sum
    import fwm_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = fwm_cnt_w(N),
    localparam int PW = 2 * N
) (
    input  logic [N-1:0][N-1:0] pp,
    input  logic [CW-1:0]       bias,
    output logic [N-1:0]        hi
);

    localparam logic [PW-1:0] CORR = (PW'(1) << N) | (PW'(1) << (PW - 1));
    localparam int INJ = N - FWM_KEEP_EXTRA;

    logic [PW-1:0] rows [N];
    logic [PW-1:0] acc;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rows[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (fwm_col_kept(i, j, N)) begin
                    rows[i][i+j] = pp[i][j];
                end
            end
        end
    end

    always_comb begin
        acc = CORR + (PW'(bias) << INJ);
        for (int i = 0; i < N; i++) begin
            acc = acc + rows[i];
        end
    end

    // carry out of column PW-1 is dropped
    assign hi = acc[PW-1:N];

endmodule

// File: rtl/fwm_trunc_mul.sv
module fwm_trunc_mul
    import fwm_pkg::*;
#(
    parameter int         N     = 8,
    parameter fwm_stage_e STAGE = FWM_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] prod
);

    localparam int CW = fwm_cnt_w(N);

    logic [N-1:0][N-1:0] pp;
    logic [CW-1:0]       bias;
    logic [N-1:0]        hi;

    fwm_pp_array #(.N(N)) u_pp (
        .a  (op_a),
        .b  (op_b),
        .pp (pp)
    );

    fwm_bias_gen #(.N(N)) u_bias (
        .pp   (pp),
        .bias (bias)
    );

    fwm_col_sum #(.N(N)) u_sum (
        .pp   (pp),
        .bias (bias),
        .hi   (hi)
    );

    if (STAGE == FWM_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) prod <= '0;
            else     prod <= hi;
        end
    end else begin : g_comb
        assign prod = hi;
    end

endmodule

// File: rtl/fwm_trunc_mul_chk.sv
module fwm_trunc_mul_chk
    import fwm_pkg::*;
#(
    parameter int         N     = 8,
    parameter fwm_stage_e STAGE = FWM_REG
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic [N-1:0] prod
);

    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MOST_POS = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] SQ_NEG   = N'(1) << (N - 2);
    localparam logic [N-1:0] MIX_FULL = N'(0) - (SQ_NEG - N'(1));

    logic [N-1:0] a_d, b_d;
    logic         seen;

    if (STAGE == FWM_REG) begin : g_dly
        always_ff @(posedge clk) begin
            a_d  <= op_a;
            b_d  <= op_b;
            seen <= !rst;
        end
    end else begin : g_now
        assign a_d  = op_a;
        assign b_d  = op_b;
        assign seen = 1'b1;
    end

    logic signed [2*N-1:0] full_p;
    logic        [N-1:0]   ref_hi;
    logic        [N:0]     diff;

    assign full_p = $signed(a_d) * $signed(b_d);
    assign ref_hi = full_p[2*N-1:N];
    assign diff   = {prod[N-1], prod} - {ref_hi[N-1], ref_hi};

    // R6
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (STAGE == FWM_REG && $fell(rst)) |-> prod == '0);

    // R2
    err_bound_chk: assert property (@(posedge clk) disable iff (rst)
        seen |-> (diff == '0 || diff == (N+1)'(1) || diff == '1));

    // R3
    zero_op_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && (a_d == '0 || b_d == '0)) |-> prod == '0);

    // R4
    neg_square_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && a_d == MOST_NEG && b_d == MOST_NEG) |-> prod == SQ_NEG);

    // R7
    mixed_full_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && ((a_d == MOST_NEG && b_d == MOST_POS) ||
                  (a_d == MOST_POS && b_d == MOST_NEG))) |-> prod == MIX_FULL);

endmodule

bind fwm_trunc_mul fwm_trunc_mul_chk #(.N(N), .STAGE(STAGE)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/sim_fwm_trunc_mul.sv
`timescale 1ns/1ps
module sim_fwm_trunc_mul;

    localparam int N = 8;
    localparam int LO = -(1 << (N - 1));
    localparam int HI = (1 << (N - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic [N-1:0] prod;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    longint err_ours  = 0;
    longint err_trunc = 0;

    always #2.5 clk = ~clk;

    fwm_trunc_mul #(.N(N)) u0 (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    function automatic int bitv(int v, int i);
        return (v >> i) & 1;
    endfunction

    // R1 model: drop low magnitude pairs, add ceil(S/2)+1 at column N-1
    function automatic int model_out(int x, int y);
        int p = x * y;
        int d = 0;
        int s = 0;
        int bsum;
        int v;
        for (int i = 0; i <= N - 2; i++) begin
            for (int j = 0; j <= N - 2; j++) begin
                if (i + j <= N - 2 && bitv(x, i) == 1 && bitv(y, j) == 1) begin
                    d += (1 << (i + j));
                    if (i + j == N - 2) s++;
                end
            end
        end
        bsum = (s + 1) / 2 + 1;
        v = (p - d + bsum * (1 << (N - 1))) >>> N;
        return v;
    endfunction

    // plain truncation: drop all columns below N, no bias
    function automatic int trunc_out(int x, int y);
        int p = x * y;
        int d = 0;
        for (int i = 0; i <= N - 2; i++) begin
            for (int j = 0; j <= N - 2; j++) begin
                if (i + j <= N - 1 && bitv(x, i) == 1 && bitv(y, j) == 1)
                    d += (1 << (i + j));
            end
        end
        return (p - d) >>> N;
    endfunction

    function automatic int to_int(logic [N-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(int x, int y);
        @(negedge clk);
        op_a = N'(x);
        op_b = N'(y);
        @(negedge clk);
    endtask

    task automatic exact_vec(string req, int x, int y, int exp);
        apply(x, y);
        check(req, to_int(prod), exp);
    endtask

    initial begin
        int prev;
        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 reset", to_int(prod), 0);
        rst = 1'b0;

        // R3: zero operands
        exact_vec("R3 zero a", 0, HI, 0);
        exact_vec("R3 zero b", LO, 0, 0);
        exact_vec("R3 both zero", 0, 0, 0);
        // R4: most negative squared
        exact_vec("R4 neg square", LO, LO, 1 << (N - 2));
        // R7: mixed full scale
        exact_vec("R7 neg*pos", LO, HI, -((1 << (N - 2)) - 1));
        exact_vec("R7 pos*neg", HI, LO, -((1 << (N - 2)) - 1));
        // R1: a few hand picks
        exact_vec("R1 pos square", HI, HI, model_out(HI, HI));
        exact_vec("R1 minus one", -1, -1, model_out(-1, -1));

        // R6: output holds until the clock edge
        prev = to_int(prod);
        op_a = N'(37);
        op_b = N'(-91);
        #1;
        check("R6 hold before edge", to_int(prod), prev);
        @(negedge clk);
        check("R6 after edge", to_int(prod), model_out(37, -91));

        // R1, R2, R5: exhaustive sweep
        for (int x = LO; x <= HI; x++) begin
            for (int y = LO; y <= HI; y++) begin
                int got;
                int p;
                int fl;
                int dv;
                int t0;
                apply(x, y);
                got = to_int(prod);
                p   = x * y;
                check("R1 model", got, model_out(x, y));
                fl = p >>> N;
                dv = got - fl;
                total++;
                if (dv > 1 || dv < -1) begin
                    bad++;
                    $display("FAIL R2 a=%0d b=%0d: got %0d expected %0d +/-1", x, y, got, fl);
                end
                err_ours += (got * (1 << N) - p >= 0) ? (got * (1 << N) - p) : (p - got * (1 << N));
                t0 = trunc_out(x, y);
                err_trunc += (t0 * (1 << N) - p >= 0) ? (t0 * (1 << N) - p) : (p - t0 * (1 << N));
            end
        end

        // R5: compensated error below plain truncation
        total++;
        if (!(err_ours < err_trunc)) begin
            bad++;
            $display("FAIL R5: got error sum %0d expected below %0d", err_ours, err_trunc);
        end

        // R6: synchronous reset mid-run
        apply(HI, HI);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R6 mid reset", to_int(prod), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule